// File: doc/BRIEF.md
# Luma/Chroma Ancillary Word Buffer with Encoded Fill Status

This block holds ancillary words waiting to be placed into a high-definition video stream. It contains two independent 1024-word buffers of 10-bit words, one for the luma channel and one for the chroma channel. Words are loaded on a write clock that is unrelated to the pixel clock. They are drawn out at the pixel clock, in the order they were loaded. A single select input chooses the buffer used for writes, for reads and for the status output.

The fill level of the selected buffer is reported as a 3-bit code with eight values. The low codes (underrun, empty, almost empty) are formed in the pixel clock domain. The high codes (half full, almost full, full, overrun) are formed in the write clock domain and carried across to the pixel clock. Code 011 means none of the other conditions holds. The code is visible only while the status enable is low.

A downstream stream multiplexer uses the read data and its valid flag to overwrite stream words. Its valid flag is held low whenever a read finds the buffer empty.

Top module: `anc_dual_fifo`

## Requirements
- R1: While `wen_n` is low, each rising edge of `wclk` stores `wdata` in the selected buffer (`sel_luma` = 1 selects luma, 0 selects chroma), provided that buffer is not full; the other buffer is not touched.
- R2: While `ren_n` is low and the selected buffer is not empty, each rising edge of `pclk` removes the oldest word of that buffer; the word appears on `rdata` with `rvalid` high during the following `pclk` cycle, in first-in first-out order.
- R3: A read attempt on an empty buffer removes nothing and leaves `rvalid` low. The status shows 000 while such attempts continue and returns to 001 once they stop.
- R4: A write attempt on a full buffer is discarded and leaves the stored words intact. The status shows 111 while such attempts continue and returns to 110 once they stop.
- R5: Fill codes for a held count N: 001 for N = 0, 010 for 1 <= N <= 32, 011 for 33 <= N <= 511, 100 for 512 <= N <= 991, 101 for 992 <= N <= 1023, and 110 for N = 1024.
- R6: Codes 000, 001 and 010 are formed from pixel-clock state; codes 100 to 111 are formed from write-clock state. After the last operation, the code settles within three `wclk` cycles plus four `pclk` cycles.
- R7: A read at `pclk` edge k that changes a pixel-domain code shows the new code on `status` after edge k+3 and not after edge k+2.
- R8: `status`, reads and writes all follow `sel_luma`; activity on one buffer does not alter the status or contents of the other.
- R9: While `stat_en_n` is high, `status` is 011 regardless of the fill level.
- R10: While `rst_n` is low, both buffers are emptied (both pointers return to zero) and the status register holds 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| pclk | input | 1 | Pixel clock, read side and status |
| rst_n | input | 1 | Active-low reset of both buffers, asynchronous |
| sel_luma | input | 1 | Buffer select: 1 luma, 0 chroma |
| wen_n | input | 1 | Active-low write enable (wclk domain) |
| wdata | input | 10 | Word to store |
| ren_n | input | 1 | Active-low read enable (pclk domain) |
| stat_en_n | input | 1 | Active-low status output enable |
| rdata | output | 10 | Word read out |
| rvalid | output | 1 | rdata holds a word removed on the previous pclk edge |
| status | output | 3 | Encoded fill code of the selected buffer |

## Verification
The hardest states to reach are the two error codes. The buffer must first be brought exactly to 1024 words, or drained to zero, and the bad request must then be held long enough for the code to cross into the pixel domain. The stimulus loads the luma buffer word by word to 1024 and checks every level boundary on the way. It then holds the write enable low against the full buffer while the status is sampled, and drains all 1024 words to show that none was overwritten. The pixel-domain latency is checked by a single read that moves the count from 33 to 32, with the code sampled on both sides of the third edge.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;

    typedef enum logic [2:0] {
        ST_UNDER  = 3'b000,
        ST_EMPTY  = 3'b001,
        ST_AEMPTY = 3'b010,
        ST_READY  = 3'b011,
        ST_HALF   = 3'b100,
        ST_AFULL  = 3'b101,
        ST_FULL   = 3'b110,
        ST_OVER   = 3'b111
    } stat_code_t;

    typedef struct packed {
        logic       hit;
        stat_code_t code;
    } tagged_code_t;

endpackage

// File: rtl/anc_ptr_sync.sv
module anc_ptr_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = gray_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bin_o[W-1] = st_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ st_q.s2[i];
        end
    end

endmodule

// File: rtl/anc_fifo_chan.sv
module anc_fifo_chan
    import anc_fifo_pkg::*;
#(
    parameter int DW       = 10,
    parameter int AW       = 10,
    parameter int AE_LVL   = 32,
    parameter int HALF_LVL = 512,
    parameter int AF_LVL   = 992
) (
    input  logic          wclk,
    input  logic          pclk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wdata,
    input  logic          rd_req,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output stat_code_t    code_o
);

    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] AE_P    = PW'(AE_LVL);
    localparam logic [PW-1:0] HALF_P  = PW'(HALF_LVL);
    localparam logic [PW-1:0] AF_P    = PW'(AF_LVL);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
        tagged_code_t  tc;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          vld;
        logic          udf;
        tagged_code_t  rc;
        tagged_code_t  ws1;
        tagged_code_t  ws2;
        stat_code_t    code;
    } rd_st_t;

    wr_st_t w_d, w_q;
    rd_st_t r_d, r_q;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rptr_w, wptr_r;
    logic [PW-1:0] wcnt, rcnt;
    logic          wfull, rempty, wr_go, rd_go;

    anc_ptr_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_i(r_q.gray), .bin_o(rptr_w)
    );

    anc_ptr_sync #(.W(PW)) u_w2r (
        .clk(pclk), .rst_n(rst_n), .gray_i(w_q.gray), .bin_o(wptr_r)
    );

    // ---------------- write clock domain ----------------
    always_comb begin
        w_d    = w_q;
        wcnt   = w_q.bin - rptr_w;
        wfull  = (wcnt == DEPTH_P);
        wr_go  = wr_req && !wfull;
        w_d.bin  = w_q.bin + PW'(wr_go);
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        w_d.ovf  = wr_req && wfull;
        w_d.tc.hit = 1'b1;
        if (w_q.ovf)            w_d.tc.code = ST_OVER;
        else if (wfull)         w_d.tc.code = ST_FULL;
        else if (wcnt >= AF_P)  w_d.tc.code = ST_AFULL;
        else if (wcnt >= HALF_P) w_d.tc.code = ST_HALF;
        else begin
            w_d.tc.hit  = 1'b0;
            w_d.tc.code = ST_READY;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            w_q         <= '0;
            w_q.tc.code <= ST_READY;
        end else begin
            w_q <= w_d;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_go) mem[w_q.bin[AW-1:0]] <= wdata;
    end

    // ---------------- pixel clock domain ----------------
    always_comb begin
        r_d    = r_q;
        rcnt   = wptr_r - r_q.bin;
        rempty = (rcnt == '0);
        rd_go  = rd_req && !rempty;
        r_d.bin  = r_q.bin + PW'(rd_go);
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);
        r_d.vld  = rd_go;
        r_d.udf  = rd_req && rempty;
        if (rd_go) r_d.data = mem[r_q.bin[AW-1:0]];
        r_d.rc.hit = 1'b1;
        if (r_q.udf)            r_d.rc.code = ST_UNDER;
        else if (rempty)        r_d.rc.code = ST_EMPTY;
        else if (rcnt <= AE_P)  r_d.rc.code = ST_AEMPTY;
        else begin
            r_d.rc.hit  = 1'b0;
            r_d.rc.code = ST_READY;
        end
        r_d.ws1 = w_q.tc;
        r_d.ws2 = r_q.ws1;
        if (r_q.rc.hit && r_q.rc.code == ST_UNDER)        r_d.code = ST_UNDER;
        else if (r_q.ws2.hit && r_q.ws2.code == ST_OVER)  r_d.code = ST_OVER;
        else if (r_q.rc.hit)                              r_d.code = r_q.rc.code;
        else if (r_q.ws2.hit)                             r_d.code = r_q.ws2.code;
        else                                              r_d.code = ST_READY;
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.rc.hit   <= 1'b1;
            r_q.rc.code  <= ST_EMPTY;
            r_q.ws1.code <= ST_READY;
            r_q.ws2.code <= ST_READY;
            r_q.code     <= ST_EMPTY;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata  = r_q.data;
    assign rvalid = r_q.vld;
    assign code_o = r_q.code;

    // ---------------- assertions ----------------
    AST_WCNT_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
        wcnt <= DEPTH_P); // R5
    AST_RCNT_BOUND: assert property (@(posedge pclk) disable iff (!rst_n)
        rcnt <= DEPTH_P); // R5
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_req && wfull) |=> $stable(w_q.bin)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge pclk) disable iff (!rst_n)
        (rd_req && rempty) |=> ($stable(r_q.bin) && !rvalid)); // R3
    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(w_q.gray ^ $past(w_q.gray)) <= 1); // R1
    AST_RGRAY_STEP: assert property (@(posedge pclk) disable iff (!rst_n)
        $countones(r_q.gray ^ $past(r_q.gray)) <= 1); // R2

endmodule

// File: rtl/anc_dual_fifo.sv
module anc_dual_fifo
    import anc_fifo_pkg::*;
#(
    parameter int DW       = 10,
    parameter int AW       = 10,
    parameter int AE_LVL   = 32,
    parameter int HALF_LVL = 512,
    parameter int AF_LVL   = 992
) (
    input  logic          wclk,
    input  logic          pclk,
    input  logic          rst_n,
    input  logic          sel_luma,
    input  logic          wen_n,
    input  logic [DW-1:0] wdata,
    input  logic          ren_n,
    input  logic          stat_en_n,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [2:0]    status
);

    localparam int NCH = 2;   // index 0 chroma, 1 luma

    typedef struct packed {
        stat_code_t code;
    } top_st_t;

    top_st_t t_d, t_q;

    logic [DW-1:0] ch_rdata [NCH];
    logic [NCH-1:0] ch_valid;
    stat_code_t    ch_code  [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic is_sel;
        assign is_sel = (sel_luma == (c == 1));
        anc_fifo_chan #(
            .DW(DW), .AW(AW), .AE_LVL(AE_LVL),
            .HALF_LVL(HALF_LVL), .AF_LVL(AF_LVL)
        ) u_chan (
            .wclk(wclk), .pclk(pclk), .rst_n(rst_n),
            .wr_req(!wen_n && is_sel), .wdata(wdata),
            .rd_req(!ren_n && is_sel),
            .rdata(ch_rdata[c]), .rvalid(ch_valid[c]),
            .code_o(ch_code[c])
        );
    end

    always_comb begin
        t_d      = t_q;
        t_d.code = sel_luma ? ch_code[1] : ch_code[0];
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) t_q.code <= ST_EMPTY;
        else        t_q      <= t_d;
    end

    assign rvalid = |ch_valid;
    assign rdata  = ch_valid[1] ? ch_rdata[1] : ch_rdata[0];
    assign status = stat_en_n ? 3'(ST_READY) : 3'(t_q.code);

    AST_ONE_SOURCE: assert property (@(posedge pclk) disable iff (!rst_n)
        $onehot0(ch_valid)); // R8

endmodule

// File: tb/sim_anc_dual_fifo.sv
module sim_anc_dual_fifo;

    logic       wclk = 1'b0, pclk = 1'b0;
    logic       rst_n = 1'b0, sel_luma = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
    logic       stat_en_n = 1'b0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic       rvalid;
    logic [2:0] status;

    int tests = 0, fails = 0, nvalid = 0;
    logic [9:0] q_l[$];
    logic [9:0] q_c[$];
    logic rd_ch = 1'b1;
    logic [9:0] exp_w;

    always #10 pclk = ~pclk;   // 50 MHz pixel clock
    always #7  wclk = ~wclk;

    anc_dual_fifo u0 (
        .wclk(wclk), .pclk(pclk), .rst_n(rst_n), .sel_luma(sel_luma),
        .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n), .stat_en_n(stat_en_n),
        .rdata(rdata), .rvalid(rvalid), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference comparison of read data on every pixel clock
    always @(negedge pclk) begin
        if (rst_n && rvalid) begin
            nvalid++;
            if (rd_ch) begin
                if (q_l.size() == 0) check("R2 luma word with empty model", 1, 0);
                else begin exp_w = q_l.pop_front(); check("R2 luma order", rdata, exp_w); end
            end else begin
                if (q_c.size() == 0) check("R2 chroma word with empty model", 1, 0);
                else begin exp_w = q_c.pop_front(); check("R2 chroma order", rdata, exp_w); end
            end
        end
    end

    task automatic settle();
        repeat (6) @(posedge wclk);
        repeat (8) @(posedge pclk);
    endtask

    task automatic st_chk(input string req, input int exp);
        @(negedge pclk);
        check(req, status, exp);
    endtask

    task automatic wr_n(input int n, input int base);
        @(posedge wclk); #1;
        for (int i = 0; i < n; i++) begin
            wdata = 10'((base + i * 7) & 10'h3ff);
            wen_n = 1'b0;
            @(posedge wclk);
            if (sel_luma) begin if (q_l.size() < 1024) q_l.push_back(wdata); end
            else          begin if (q_c.size() < 1024) q_c.push_back(wdata); end
            #1;
        end
        wen_n = 1'b1;
    endtask

    task automatic rd_n(input int n);
        rd_ch = sel_luma;
        @(posedge pclk); #1;
        ren_n = 1'b0;
        repeat (n) @(posedge pclk);
        #1 ren_n = 1'b1;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int v0;
        #33;
        st_chk("R10 status during reset", 1);
        #5 rst_n = 1'b1;
        settle();
        st_chk("R5 empty after reset", 1);
        check("R2 no valid when idle", rvalid, 0);

        stat_en_n = 1'b1;
        st_chk("R9 disabled status forced", 3);
        stat_en_n = 1'b0;

        // luma almost-empty boundary
        sel_luma = 1'b1;
        wr_n(32, 5);  settle();
        st_chk("R5 32 words almost empty", 2);
        wr_n(1, 900); settle();
        st_chk("R5 33 words ready", 3);

        // exact read-side latency: 33 -> 32
        rd_ch = 1'b1;
        @(posedge pclk); #1 ren_n = 1'b0;
        @(posedge pclk); #1 ren_n = 1'b1;   // edge k
        @(negedge pclk); @(negedge pclk);
        @(negedge pclk); check("R7 old code after edge k+2", status, 3);
        @(negedge pclk); check("R7 new code after edge k+3", status, 2);

        // chroma isolation
        sel_luma = 1'b0; settle();
        st_chk("R8 chroma empty while luma holds words", 1);
        wr_n(5, 300); settle();
        st_chk("R5 chroma 5 words", 2);
        sel_luma = 1'b1; settle();
        st_chk("R8 luma unchanged by chroma writes", 2);
        sel_luma = 1'b0;
        v0 = nvalid;
        rd_n(5); settle();
        check("R2 chroma words read", nvalid - v0, 5);
        check("R8 chroma model drained", q_c.size(), 0);

        // underrun on chroma
        v0 = nvalid;
        rd_ch = 1'b0;
        @(posedge pclk); #1 ren_n = 1'b0;
        repeat (6) @(negedge pclk);
        check("R3 underrun code while reading empty", status, 0);
        repeat (4) @(posedge pclk);
        #1 ren_n = 1'b1;
        check("R3 no data during underrun", nvalid - v0, 0);
        settle();
        st_chk("R3 back to empty after underrun", 1);
        st_chk("R6 chroma read-domain code settled", 1);

        // luma level ladder
        sel_luma = 1'b1; settle();
        wr_n(511 - q_l.size(), 17); settle();
        st_chk("R5 511 words ready", 3);
        wr_n(1, 40); settle();
        st_chk("R5 512 words half", 4);
        wr_n(479, 61); settle();
        st_chk("R5 991 words half", 4);
        wr_n(1, 2); settle();
        st_chk("R5 992 words almost full", 5);
        wr_n(31, 99); settle();
        st_chk("R5 1023 words almost full", 5);
        wr_n(1, 11); settle();
        st_chk("R5 1024 words full", 6);
        check("R1 model holds 1024", q_l.size(), 1024);

        // overrun
        @(posedge wclk); #1 wdata = 10'h3ff; wen_n = 1'b0;
        repeat (10) @(negedge pclk);
        check("R4 overrun code while writing full", status, 7);
        @(posedge wclk); #1 wen_n = 1'b1;
        settle();
        st_chk("R4 back to full after overrun", 6);
        sel_luma = 1'b0; settle();
        st_chk("R8 chroma still empty", 1);
        sel_luma = 1'b1; settle();

        // drain all, checking no word was overwritten
        v0 = nvalid;
        rd_n(1024); settle();
        check("R4 all 1024 words intact", nvalid - v0, 1024);
        check("R2 luma model drained", q_l.size(), 0);
        st_chk("R5 empty after drain", 1);

        // reset mid-run
        wr_n(10, 500);
        sel_luma = 1'b0;
        wr_n(3, 600); settle();
        sel_luma = 1'b1;
        @(negedge pclk); rst_n = 1'b0;
        q_l.delete(); q_c.delete();
        #41 rst_n = 1'b1;
        settle();
        st_chk("R10 luma empty after reset", 1);
        v0 = nvalid;
        rd_n(3); settle();
        check("R10 no luma data after reset", nvalid - v0, 0);
        sel_luma = 1'b0; settle();
        st_chk("R10 chroma empty after reset", 1);
        rd_n(3); settle();
        check("R10 no chroma data after reset", nvalid - v0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule